// File: doc/BRIEF.md
# Three-wire synthesizer register programmer

This block is the master side of a serial configuration link built from three wires: a serial clock, a serial data line and a load strobe. It programs one or more frequency-synthesizer devices. A host hands it write requests through a ready/valid port. Each request names a target device, gives a configuration word and gives a wait count. Requests queue in a small buffer and are served in arrival order. Each word goes out most significant bit first. The target's load strobe frames the word: the strobe drops before the first bit, and it comes back high on a serial-clock rising edge, which is when the device latches the shifted word into its internal register.

Clock and data are shared by every attached device. Only the load strobe of the addressed device moves, so only that device takes the word. A separate chip-enable output per device follows a host power mask and is independent of programming. After each word the block waits for the request's own number of system-clock cycles before it starts the next word. A host uses this wait to respect the write order and the settling gaps the synthesizer needs between certain registers. Every serial output is driven straight from a flip-flop, so no decode glitch reaches the wires.

Top module: `tw_synth_writer`

## Requirements
- R1: Out of reset the serial clock is low, serial data is low, every load strobe is high, busy is low, req_ready is high and every chip-enable is low.
- R2: A frame starts when exactly one load strobe falls while the serial clock is low. Exactly WORD_W serial-clock rising edges then occur while that strobe is low.
- R3: The bits sampled on those rising edges are the request word, most significant bit first.
- R4: Serial data never changes while the serial clock is high. It changes only at a serial-clock falling edge or at the start of a frame.
- R5: The load strobe returns high in the same system-clock cycle as a serial-clock rising edge. The serial clock falls again HALF_DIV cycles later.
- R6: Only the strobe at position req_dev of the le vector pulses for a request, and at no time is more than one strobe low.
- R7: From the start of a frame until the clock falls after the latch edge, every serial-clock phase, including the first low phase after the strobe falls, lasts exactly HALF_DIV system-clock cycles.
- R8: When the next request is already queued, the next frame's strobe falls exactly HALF_DIV + 2 + req_delay system-clock cycles after the previous strobe rose. Here req_delay is the wait count of the earlier request.
- R9: Requests are served in acceptance order. req_ready is low while FIFO_DEPTH requests are queued, and a request is taken only on a cycle where req_valid and req_ready are both high.
- R10: busy is high from the cycle after a request is accepted. Once the queue is empty, busy falls HALF_DIV + 1 + req_delay cycles after the last strobe rose.
- R11: Each chip-enable output equals the matching bit of dev_power one system-clock cycle later, including while a frame is on the wire.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| req_valid | input | 1 | Host offers a write request |
| req_ready | output | 1 | Queue has room; request taken when both high |
| req_dev | input | DEV_W | Index of the target device |
| req_word | input | WORD_W | Configuration word, sent MSB first |
| req_delay | input | DLY_W | System-clock cycles to wait after this word |
| dev_power | input | NDEV | Requested chip-enable state per device |
| sclk | output | 1 | Shared serial clock, idle low |
| sdata | output | 1 | Shared serial data |
| le | output | NDEV | Per-device load strobe, active low, idle high |
| ce | output | NDEV | Per-device chip-enable |
| busy | output | 1 | A request is queued, on the wire or in its wait |

## Verification
The bench builds the block with three devices, a 12-bit word, a serial half-period of two system clocks, an 8-bit wait count and a two-entry queue. The short word and fast serial clock keep each frame near fifty cycles, so many frames fit in a short run. The two-entry queue lets three quick requests fill the buffer while the first frame is still on the wire, which exposes backpressure. It also creates back-to-back frames in which the exact inter-frame gap can be measured for zero and non-zero waits. Three devices are enough to show that only the addressed strobe moves and that the last index is decoded correctly.

// File: rtl/tws_pkg.sv
// Package: shared types for the three-wire synthesizer programmer.
// Assumes: nothing beyond IEEE 1800-2017 enums.
package tws_pkg;

    // Phases of the serial frame engine
    typedef enum logic [2:0] {
        ST_IDLE  = 3'd0,   // wires idle, waiting for a queued request
        ST_LO    = 3'd1,   // serial clock low, data presented
        ST_HI    = 3'd2,   // serial clock high, device samples
        ST_TAIL  = 3'd3,   // clock low after the last bit
        ST_LATCH = 3'd4,   // clock and strobe high together
        ST_WAIT  = 3'd5    // post-write wait count running
    } tws_state_e;

endpackage

// File: rtl/tws_fifo.sv
// Module: tws_fifo
// Holds pending write requests in arrival order (first-word fall-through).
// Assumes: the writer honours 'full'; pop is only raised when not empty.
module tws_fifo #(
    parameter int ENTRY_W = 32,
    parameter int DEPTH   = 4
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               push,
    input  logic [ENTRY_W-1:0] wdata,
    input  logic               pop,
    output logic [ENTRY_W-1:0] rdata,
    output logic               nonempty,
    output logic               full
);
    localparam int PW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam int CW = $clog2(DEPTH + 1);

    logic [ENTRY_W-1:0] mem [DEPTH];
    logic [PW-1:0]      wr_ptr, rd_ptr;
    logic [CW-1:0]      cnt;
    logic               do_push, do_pop;

    assign do_push  = push && !full;
    assign do_pop   = pop && nonempty;
    assign rdata    = mem[rd_ptr];
    assign nonempty = (cnt != '0);
    assign full     = (cnt == CW'(DEPTH));

    // Storage write; no reset needed on the data array
    always_ff @(posedge clk) begin
        if (do_push) mem[wr_ptr] <= wdata;
    end

    // Pointer and occupancy bookkeeping
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wr_ptr <= '0;
            rd_ptr <= '0;
            cnt    <= '0;
        end else begin
            if (do_push) wr_ptr <= (wr_ptr == PW'(DEPTH - 1)) ? '0 : wr_ptr + 1'b1;
            if (do_pop)  rd_ptr <= (rd_ptr == PW'(DEPTH - 1)) ? '0 : rd_ptr + 1'b1;
            case ({do_push, do_pop})
                2'b10:   cnt <= cnt + 1'b1;
                2'b01:   cnt <= cnt - 1'b1;
                default: cnt <= cnt;
            endcase
        end
    end

    // A full queue that is not drained stays full whatever the writer does
    assert_full_holds_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (full && !pop) |=> full);

endmodule

// File: rtl/tws_engine.sv
// Module: tws_engine
// Serialises one queued word per frame onto the shared clock/data wires,
// frames it with the addressed device's load strobe and then runs the
// request's post-write wait before taking the next request.
// Assumes: HALF_DIV >= 1; q_dev < NDEV. All wire outputs are flops.
module tws_engine
    import tws_pkg::*;
#(
    parameter int NDEV     = 4,
    parameter int WORD_W   = 24,
    parameter int DLY_W    = 16,
    parameter int HALF_DIV = 4,
    parameter int DEV_W    = (NDEV > 1) ? $clog2(NDEV) : 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              q_valid,
    input  logic [DEV_W-1:0]  q_dev,
    input  logic [WORD_W-1:0] q_word,
    input  logic [DLY_W-1:0]  q_delay,
    output logic              q_pop,
    output logic              active,
    output logic              sclk,
    output logic              sdata,
    output logic [NDEV-1:0]   le
);
    localparam int TW   = (HALF_DIV > 1) ? $clog2(HALF_DIV) : 1;
    localparam int BW   = (WORD_W > 1) ? $clog2(WORD_W) : 1;
    localparam logic [TW-1:0] TMAX = TW'(HALF_DIV - 1);
    localparam logic [BW-1:0] LAST = BW'(WORD_W - 1);

    tws_state_e        st;
    logic [TW-1:0]     timer;
    logic [BW-1:0]     bitc;
    logic [WORD_W-1:0] shreg;
    logic [DLY_W-1:0]  dly_q, dcnt;

    assign q_pop  = (st == ST_IDLE) && q_valid;
    assign active = (st != ST_IDLE);

    // Frame sequencer: clock phases, data shifting, strobe framing, wait
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st    <= ST_IDLE;
            sclk  <= 1'b0;
            sdata <= 1'b0;
            le    <= '1;
            timer <= '0;
            bitc  <= '0;
            shreg <= '0;
            dly_q <= '0;
            dcnt  <= '0;
        end else begin
            case (st)
                ST_IDLE: begin
                    if (q_valid) begin
                        for (int i = 0; i < NDEV; i++) begin
                            if (q_dev == DEV_W'(i)) le[i] <= 1'b0;
                        end
                        sdata <= q_word[WORD_W-1];
                        shreg <= q_word << 1;
                        dly_q <= q_delay;
                        timer <= TMAX;
                        bitc  <= '0;
                        st    <= ST_LO;
                    end
                end
                ST_LO: begin
                    if (timer == '0) begin
                        sclk  <= 1'b1;
                        timer <= TMAX;
                        st    <= ST_HI;
                    end else begin
                        timer <= timer - 1'b1;
                    end
                end
                ST_HI: begin
                    if (timer == '0) begin
                        sclk  <= 1'b0;
                        timer <= TMAX;
                        if (bitc == LAST) begin
                            sdata <= 1'b0;
                            st    <= ST_TAIL;
                        end else begin
                            bitc  <= bitc + 1'b1;
                            sdata <= shreg[WORD_W-1];
                            shreg <= shreg << 1;
                            st    <= ST_LO;
                        end
                    end else begin
                        timer <= timer - 1'b1;
                    end
                end
                ST_TAIL: begin
                    if (timer == '0) begin
                        sclk  <= 1'b1;
                        le    <= '1;
                        timer <= TMAX;
                        st    <= ST_LATCH;
                    end else begin
                        timer <= timer - 1'b1;
                    end
                end
                ST_LATCH: begin
                    if (timer == '0) begin
                        sclk <= 1'b0;
                        dcnt <= dly_q;
                        st   <= ST_WAIT;
                    end else begin
                        timer <= timer - 1'b1;
                    end
                end
                ST_WAIT: begin
                    if (dcnt == '0) st <= ST_IDLE;
                    else            dcnt <= dcnt - 1'b1;
                end
                default: st <= ST_IDLE;
            endcase
        end
    end

    // Idle wire levels right after reset
    assert_reset_idle_R1: assert property (@(posedge clk)
        !rst_n |=> (!sclk && !sdata && (&le)));

    // A strobe only falls while the serial clock is low
    assert_frame_start_low_R2: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(&le) |-> !sclk);

    // Data is held for the whole high phase of the serial clock
    assert_data_steady_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (sclk && $past(sclk)) |-> $stable(sdata));

    // Strobe release coincides with a serial-clock rising edge
    assert_latch_on_rise_R5: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(&le) |-> $rose(sclk));

    // At most one device is selected at any time
    assert_one_strobe_R6: assert property (@(posedge clk) disable iff (!rst_n)
        $countones(~le) <= 1);

endmodule

// File: rtl/tws_ce_bank.sv
// Module: tws_ce_bank
// Registers the host power mask onto one chip-enable flop per device.
// Assumes: dev_power is synchronous to clk.
module tws_ce_bank #(
    parameter int NDEV = 4
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic [NDEV-1:0] dev_power,
    output logic [NDEV-1:0] ce
);
    for (genvar g = 0; g < NDEV; g++) begin : g_ce
        // One chip-enable flop per device, off in reset
        always_ff @(posedge clk) begin
            if (!rst_n) ce[g] <= 1'b0;
            else        ce[g] <= dev_power[g];
        end

        assert_ce_follows_R11: assert property (@(posedge clk) disable iff (!rst_n)
            rst_n |=> (ce[g] == $past(dev_power[g])));
    end

endmodule

// File: rtl/tw_synth_writer.sv
// Module: tw_synth_writer (top)
// Master of a three-wire configuration link for frequency synthesizers:
// queues host write requests, serialises each word to the addressed
// device and enforces a per-request wait after each write.
// Assumes: host keeps req_dev < NDEV; serial wires are flop-driven.
module tw_synth_writer #(
    parameter int NDEV       = 4,
    parameter int WORD_W     = 24,
    parameter int DLY_W      = 16,
    parameter int HALF_DIV   = 4,
    parameter int FIFO_DEPTH = 4,
    parameter int DEV_W      = (NDEV > 1) ? $clog2(NDEV) : 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    output logic              req_ready,
    input  logic [DEV_W-1:0]  req_dev,
    input  logic [WORD_W-1:0] req_word,
    input  logic [DLY_W-1:0]  req_delay,
    input  logic [NDEV-1:0]   dev_power,
    output logic              sclk,
    output logic              sdata,
    output logic [NDEV-1:0]   le,
    output logic [NDEV-1:0]   ce,
    output logic              busy
);
    localparam int ENTRY_W = DEV_W + WORD_W + DLY_W;

    logic [ENTRY_W-1:0] q_in, q_out;
    logic               q_nonempty, q_full, q_pop, eng_active;
    logic [DEV_W-1:0]   q_dev;
    logic [WORD_W-1:0]  q_word;
    logic [DLY_W-1:0]   q_delay;

    assign q_in      = {req_dev, req_word, req_delay};
    assign {q_dev, q_word, q_delay} = q_out;
    assign req_ready = !q_full;
    assign busy      = q_nonempty || eng_active;

    tws_fifo #(.ENTRY_W(ENTRY_W), .DEPTH(FIFO_DEPTH)) u_fifo (
        .clk      (clk),
        .rst_n    (rst_n),
        .push     (req_valid),
        .wdata    (q_in),
        .pop      (q_pop),
        .rdata    (q_out),
        .nonempty (q_nonempty),
        .full     (q_full)
    );

    tws_engine #(
        .NDEV(NDEV), .WORD_W(WORD_W), .DLY_W(DLY_W),
        .HALF_DIV(HALF_DIV), .DEV_W(DEV_W)
    ) u_engine (
        .clk     (clk),
        .rst_n   (rst_n),
        .q_valid (q_nonempty),
        .q_dev   (q_dev),
        .q_word  (q_word),
        .q_delay (q_delay),
        .q_pop   (q_pop),
        .active  (eng_active),
        .sclk    (sclk),
        .sdata   (sdata),
        .le      (le)
    );

    tws_ce_bank #(.NDEV(NDEV)) u_ce (
        .clk       (clk),
        .rst_n     (rst_n),
        .dev_power (dev_power),
        .ce        (ce)
    );

    // An accepted request keeps the block busy on the following cycle
    assert_busy_after_accept_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_ready) |=> busy);

endmodule

// File: tb/test_tw_synth_writer.sv
// Scoreboard bench: the driver pushes expected writes, the monitor decodes
// the serial wires and compares each latched frame against the queue.
module test_tw_synth_writer;
    localparam int NDEV  = 3;
    localparam int W     = 12;
    localparam int DLYW  = 8;
    localparam int H     = 2;
    localparam int DEPTH = 2;
    localparam int DEVW  = 2;

    logic            clk = 1'b0;
    logic            rst_n = 1'b0;
    logic            req_valid = 1'b0;
    logic            req_ready;
    logic [DEVW-1:0] req_dev = '0;
    logic [W-1:0]    req_word = '0;
    logic [DLYW-1:0] req_delay = '0;
    logic [NDEV-1:0] dev_power = '0;
    logic            sclk, sdata, busy;
    logic [NDEV-1:0] le, ce;

    int total = 0;
    int bad   = 0;

    typedef struct { int dev; logic [W-1:0] word; int dly; } item_t;
    item_t expq[$];

    always #4 clk = ~clk;   // 125 MHz

    tw_synth_writer #(
        .NDEV(NDEV), .WORD_W(W), .DLY_W(DLYW), .HALF_DIV(H), .FIFO_DEPTH(DEPTH)
    ) i_tw_synth_writer (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
        .req_dev(req_dev), .req_word(req_word), .req_delay(req_delay),
        .dev_power(dev_power), .sclk(sclk), .sdata(sdata), .le(le), .ce(ce),
        .busy(busy)
    );

    task automatic check(input bit ok, input string req, input int act, input int exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // Driver: offer one request, push its expectation on acceptance
    task automatic send(input int dev, input logic [W-1:0] word, input int dly);
        item_t it;
        while (!req_ready) @(negedge clk);
        req_valid = 1'b1;
        req_dev   = DEVW'(dev);
        req_word  = word;
        req_delay = DLYW'(dly);
        @(posedge clk);
        it.dev = dev; it.word = word; it.dly = dly;
        expq.push_back(it);
        @(negedge clk);
        req_valid = 1'b0;
        check(busy == 1'b1, "R10 busy after accept", busy, 1);
    endtask

    task automatic wait_idle();
        do @(negedge clk); while (busy || expq.size() != 0);
        repeat (3) @(negedge clk);
    endtask

    // Monitor state
    int cyc = 0, last_evt = 0, rise_time = 0, last_dly = 0, gap_exp = 0;
    int cur_dev = 0, bits = 0;
    bit in_frame = 0, tracking = 0, gap_armed = 0, started = 0;
    logic [W-1:0]    cap;
    logic            p_sclk = 0, p_sdata = 0, p_busy = 0;
    logic [NDEV-1:0] p_le = '1;

    // Monitor: decode wires at the falling system edge
    always @(negedge clk) begin
        logic [NDEV-1:0] fell, rose;
        cyc++;
        if (started) begin
            fell = p_le & ~le;
            rose = ~p_le & le;
            if (|fell) begin
                check(($countones(fell) == 1) && !sclk, "R2 frame start", {fell, sclk}, 0);
                if (gap_armed) check(cyc - rise_time == gap_exp, "R8 inter-frame gap",
                                     cyc - rise_time, gap_exp);
                gap_armed = 0;
                for (int i = 0; i < NDEV; i++) if (fell[i]) cur_dev = i;
                in_frame = 1; tracking = 1; bits = 0; cap = '0; last_evt = cyc;
            end
            if ((sclk != p_sclk) && tracking) begin
                check(cyc - last_evt == H, "R7 clock phase length", cyc - last_evt, H);
                last_evt = cyc;
                if (!sclk && !in_frame) tracking = 0;
            end
            if (sclk && !p_sclk && in_frame && !le[cur_dev]) begin
                bits++;
                cap = {cap[W-2:0], sdata};
            end
            if (p_sclk && sclk && (sdata != p_sdata))
                check(1'b0, "R4 data moved while clock high", sdata, p_sdata);
            if (|rose) begin
                check(sclk && !p_sclk, "R5 strobe rise on clock rise", {p_sclk, sclk}, 1);
                check(rose == (NDEV'(1) << cur_dev), "R6 single strobe", rose,
                      NDEV'(1) << cur_dev);
                if (expq.size() == 0) begin
                    check(1'b0, "R9 unexpected frame", cur_dev, 0);
                end else begin
                    item_t e;
                    e = expq.pop_front();
                    check(cur_dev == e.dev, "R6 device index", cur_dev, e.dev);
                    check(cap == e.word, "R3 word MSB first", cap, e.word);
                    check(bits == W, "R2 rising edges in frame", bits, W);
                    last_dly  = e.dly;
                    gap_exp   = H + 2 + e.dly;
                    gap_armed = (expq.size() != 0);
                end
                rise_time = cyc;
                in_frame  = 0;
            end
            if (p_busy && !busy && expq.size() == 0)
                check(cyc - rise_time == H + 1 + last_dly, "R10 busy release",
                      cyc - rise_time, H + 1 + last_dly);
        end
        p_sclk = sclk; p_sdata = sdata; p_le = le; p_busy = busy;
    end

    // Watchdog: a hung run counts as a failure and still reports
    initial begin
        repeat (100000) @(posedge clk);
        total++; bad++;
        $display("FAIL watchdog: actual=%0d expected=%0d", 100000, 0);
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    // Stimulus
    initial begin
        repeat (5) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        check(!sclk && !sdata, "R1 idle clock/data", {sclk, sdata}, 0);
        check(le == '1, "R1 idle strobes", le, 3'b111);
        check(!busy && req_ready, "R1 busy/ready", {busy, req_ready}, 1);
        check(ce == '0, "R1 chip-enables", ce, 0);
        p_le = le; p_sclk = sclk; p_sdata = sdata; p_busy = busy;
        started = 1;

        dev_power = 3'b101;
        @(negedge clk);
        check(ce == 3'b101, "R11 chip-enable follows", ce, 3'b101);

        send(0, 12'hA5C, 0);
        wait_idle();

        send(1, 12'hFFF, 3);
        send(2, 12'h001, 0);
        repeat (10) @(negedge clk);
        dev_power = 3'b010;
        @(negedge clk);
        check(ce == 3'b010, "R11 chip-enable during frame", ce, 3'b010);
        wait_idle();

        send(2, 12'h800, 20);
        send(0, 12'h3C3, 5);
        send(1, 12'h555, 0);
        check(req_ready == 1'b0, "R9 ready low when queue full", req_ready, 0);
        wait_idle();

        send(2, 12'h6B1, 37);
        send(1, 12'h0F0, 1);
        wait_idle();

        check(expq.size() == 0, "R9 all requests served in order", expq.size(), 0);
        check(le == '1 && !sclk, "R1 idle after traffic", {le, sclk}, 4'b1110);
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule